// File: doc/BRIEF.md
# Transport Stream PID Filter Bank

The block sits on a byte-wide MPEG transport stream and keeps or discards whole 188-byte packets according to their 13-bit packet identifier. A bank of eight programmable match slots is compared against the identifier of every packet at the same time. If any enabled slot holds that identifier, the packet is forwarded byte for byte on the output stream. If none does, the packet is swallowed. Slot 0 also carries three global control bits. One forwards every packet, one blocks every packet, and one selects the byte order that a downstream word packer uses.

A four-state machine tracks the packet. `S_HUNT` waits for a start strobe on a byte of value 0x47. `S_HDR1` takes header byte 1. `S_HDR2` takes header byte 2 and makes the keep/drop decision. `S_BODY` counts the remaining bytes. The transitions are:
- `S_HUNT` to `S_HDR1` on a valid sync byte with the start strobe.
- `S_HDR1` to `S_HDR2` on the next valid byte.
- `S_HDR2` to `S_BODY` on the next valid byte.
- `S_BODY` to `S_HUNT` after the last byte.
- `S_HDR1` or `S_HDR2` back to `S_HUNT` when a header byte is missing (abort).

Header bytes wait in a three-cycle delay line, so the decision covers the packet's first byte as well. The slot registers are copied into a shadow set when the sync byte is taken. Each packet is therefore judged against one stable configuration.

Top module: `ts_pidf_top`

## Requirements
- R1: After reset, `out_valid` is low. Slot 0 reads 0x03FFF: filtering blocked (bit 13), null identifier. Slots 1..7 read 0x01FFF: disabled, null identifier 0x1FFF.
- R2: Slot k lives at byte offset 4k (`reg_addr[4:2]`=k, `reg_addr[1:0]`=0). A write to slot 1..7 keeps only bit 15 and bits 12:0. A write to slot 0 keeps bits 16:0. The read is combinational and returns the stored word, with the dropped bits reading zero. A write with `reg_addr[1:0]`≠0 changes nothing, and a read there returns 0.
- R3: In `S_HUNT`, a byte is taken only when `in_valid`, `in_sop` and `in_data`=0x47 are all present. Any other byte is ignored, so a packet whose first byte is not 0x47 produces no output.
- R4: The packet identifier is {byte1[4:0], byte2}. Bits 7:5 of byte 1 do not affect the decision.
- R5: A slot hits when its bit 15 is set and its bits 12:0 equal the identifier. With slot-0 bits 16 and 13 clear, a packet passes if and only if some slot hits.
- R6: With slot-0 bit 13 set and bit 16 clear, every packet is dropped, even if a slot hits.
- R7: With slot-0 bit 16 set, every synchronised packet passes, whatever bit 13 and the slots hold.
- R8: A passed packet appears as all 188 bytes, unchanged and in order. `out_sop` marks its first byte. Each output byte leaves exactly 3 clock cycles after its input byte was taken.
- R9: Header bytes 1 and 2 must follow the sync byte on consecutive cycles. A missing header byte drops the packet and returns to `S_HUNT`. Idle cycles inside the body are allowed.
- R10: After 188 bytes the block returns to `S_HUNT`, and a start strobe inside the body is treated as ordinary data. Packets may follow each other with no idle cycle.
- R11: The configuration used for a packet is the register contents before the cycle in which its sync byte is taken. A write during a packet applies from the next packet on.
- R12: `out_order` carries slot-0 bit 14 of the packet's configuration with every output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input start-of-packet strobe |
| in_data | input | 8 | Input stream byte |
| reg_we | input | 1 | Slot register write enable |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 17 | Slot word to write |
| reg_rdata | output | 17 | Slot word at `reg_addr` |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of a forwarded packet |
| out_data | output | 8 | Output stream byte |
| out_order | output | 1 | Byte-order select for the packet being output |

## Verification
The bench sweeps every slot with its exact identifier, a one-bit neighbour, and a value that differs only in identifier bit 12. A comparator of the wrong width or with a broken enable would then pass or drop the wrong packets. The header corners are targeted too:
- A missing byte 1 or byte 2, which a design without the abort path would still forward.
- A start strobe inside the body, which a design that resynchronises there would cut the packet on.
- Back-to-back packets with opposite decisions, where a decision register updated at the wrong edge would leak or clip bytes at the boundary.

A slot write landing mid-packet shows whether the decision reads the live registers instead of the snapshot. The measured three-cycle latency catches a pipeline stage too many or too few.

// File: rtl/ts_pidf_pkg.sv
package ts_pidf_pkg;

    localparam int          PID_W     = 13;
    localparam int          WORD_W    = 17;
    localparam logic [7:0]  SYNC_BYTE = 8'h47;

    localparam int NOFIL_BIT = 16;
    localparam int EN_BIT    = 15;
    localparam int ORD_BIT   = 14;
    localparam int AOFF_BIT  = 13;

    localparam logic [WORD_W-1:0] CTL_MASK  = 17'h1FFFF;
    localparam logic [WORD_W-1:0] SLOT_MASK = 17'h09FFF;
    localparam logic [WORD_W-1:0] CTL_RST   = 17'h03FFF;
    localparam logic [WORD_W-1:0] SLOT_RST  = 17'h01FFF;

    typedef enum logic [1:0] {
        S_HUNT,
        S_HDR1,
        S_HDR2,
        S_BODY
    } pf_state_t;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic [7:0] data;
    } pf_beat_t;

endpackage

// File: rtl/ts_pidf_regs.sv
module ts_pidf_regs
    import ts_pidf_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int AW    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [WORD_W-1:0]             rd_data,
    input  logic                          snap,
    output logic [NSLOT-1:0]              sh_en,
    output logic [NSLOT-1:0][PID_W-1:0]   sh_pid,
    output logic                          sh_nofil,
    output logic                          sh_aoff,
    output logic                          sh_ord
);
    localparam int SW = AW - 2;

    logic [SW-1:0]                  sel;
    logic                           aligned;
    logic [NSLOT-1:0][WORD_W-1:0]   words;

    assign sel     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [WORD_W-1:0] MASK = (g == 0) ? CTL_MASK : SLOT_MASK;
        localparam logic [WORD_W-1:0] RSTV = (g == 0) ? CTL_RST  : SLOT_RST;

        logic [WORD_W-1:0] word_q;
        logic              en_q;
        logic [PID_W-1:0]  pid_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= RSTV;
            end else if (wr_en && aligned && (sel == SW'(g))) begin
                word_q <= wr_data & MASK;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q  <= 1'b0;
                pid_q <= '1;
            end else if (snap) begin
                en_q  <= word_q[EN_BIT];
                pid_q <= word_q[PID_W-1:0];
            end
        end

        assign words[g]  = word_q;
        assign sh_en[g]  = en_q;
        assign sh_pid[g] = pid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_nofil <= 1'b0;
            sh_aoff  <= 1'b1;
            sh_ord   <= 1'b0;
        end else if (snap) begin
            sh_nofil <= words[0][NOFIL_BIT];
            sh_aoff  <= words[0][AOFF_BIT];
            sh_ord   <= words[0][ORD_BIT];
        end
    end

    assign rd_data = aligned ? words[sel] : '0;

endmodule

// File: rtl/ts_pidf_match.sv
module ts_pidf_match
    import ts_pidf_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [PID_W-1:0]              pid,
    input  logic [NSLOT-1:0]              slot_en,
    input  logic [NSLOT-1:0][PID_W-1:0]   slot_pid,
    input  logic                          nofil,
    input  logic                          aoff,
    output logic                          pass
);
    logic [NSLOT-1:0] hit;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign hit[g] = slot_en[g] && (slot_pid[g] == pid);
    end

    assign pass = nofil || (!aoff && (|hit));

endmodule

// File: rtl/ts_pidf_top.sv
module ts_pidf_top
    import ts_pidf_pkg::*;
#(
    parameter  int NSLOT   = 8,
    parameter  int PKT_LEN = 188,
    localparam int AW      = $clog2(NSLOT) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data,
    output logic              out_order
);
    localparam int CW = $clog2(PKT_LEN);

    pf_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [4:0]  pid_hi_q;
    logic        keep_q, ord_q;
    pf_beat_t    stage_a, stage_b;

    logic        sync_ok, accept, snap, decide, abort, pass, dec_now;
    logic [NSLOT-1:0]            sh_en;
    logic [NSLOT-1:0][PID_W-1:0] sh_pid;
    logic        sh_nofil, sh_aoff, sh_ord;

    assign sync_ok = in_valid && in_sop && (in_data == SYNC_BYTE);
    assign snap    = (state_q == S_HUNT) && sync_ok;
    assign accept  = snap || (in_valid && (state_q != S_HUNT));
    assign decide  = (state_q == S_HDR2) && in_valid;
    assign abort   = ((state_q == S_HDR1) || (state_q == S_HDR2)) && !in_valid;
    assign dec_now = decide && pass;

    ts_pidf_regs #(.NSLOT(NSLOT), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .snap     (snap),
        .sh_en    (sh_en),
        .sh_pid   (sh_pid),
        .sh_nofil (sh_nofil),
        .sh_aoff  (sh_aoff),
        .sh_ord   (sh_ord)
    );

    ts_pidf_match #(.NSLOT(NSLOT)) u_match (
        .pid      ({pid_hi_q, in_data}),
        .slot_en  (sh_en),
        .slot_pid (sh_pid),
        .nofil    (sh_nofil),
        .aoff     (sh_aoff),
        .pass     (pass)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HUNT: if (sync_ok)  state_d = S_HDR1;
            S_HDR1: state_d = in_valid ? S_HDR2 : S_HUNT;
            S_HDR2: state_d = in_valid ? S_BODY : S_HUNT;
            S_BODY: if (in_valid && (cnt_q == CW'(PKT_LEN - 1))) state_d = S_HUNT;
            default: state_d = S_HUNT;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pid_hi_q  <= '0;
            keep_q    <= 1'b0;
            ord_q     <= 1'b0;
            stage_a   <= '0;
            stage_b   <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_data  <= '0;
            out_order <= 1'b0;
        end else begin
            stage_a.valid <= accept;
            stage_a.first <= snap;
            stage_a.data  <= in_data;
            stage_b       <= stage_a;

            if (state_q == S_HDR1 && in_valid) pid_hi_q <= in_data[4:0];

            if (decide) begin
                cnt_q  <= CW'(3);
                keep_q <= pass;
                ord_q  <= sh_ord;
            end else if (abort) begin
                keep_q <= 1'b0;
            end else if (state_q == S_BODY && in_valid) begin
                cnt_q <= cnt_q + 1'b1;
            end

            out_valid <= stage_b.valid && (stage_b.first ? dec_now : keep_q);
            out_sop   <= stage_b.valid && stage_b.first && dec_now;
            out_data  <= stage_b.data;
            out_order <= stage_b.first ? sh_ord : ord_q;
        end
    end

endmodule

// File: rtl/ts_pidf_chk.sv
module ts_pidf_chk
    import ts_pidf_pkg::*;
#(
    parameter int AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic [7:0]        in_data,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              out_valid,
    input logic              out_sop,
    input logic [7:0]        out_data,
    input pf_state_t         state_q
);
    // R8: every output byte was an input byte three cycles earlier
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R3: a forwarded packet starts with the sync value and is valid
    a_r3_sop_sync: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> (out_valid && out_data == SYNC_BYTE));

    // R3: without a sync start the machine keeps hunting
    a_r3_hunt_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT && !(in_valid && in_sop && in_data == SYNC_BYTE))
        |=> state_q == S_HUNT);

    // R9: a missing header byte aborts to hunting
    a_r9_hdr_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_HDR1 || state_q == S_HDR2) && !in_valid) |=> state_q == S_HUNT);

    // R2: a slot 1..7 write reads back masked on the next cycle
    a_r2_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[1:0] == 2'b00 && reg_addr[AW-1:2] != '0)
        |=> (reg_addr != $past(reg_addr)) || (reg_rdata == ($past(reg_wdata) & SLOT_MASK)));

endmodule

bind ts_pidf_top ts_pidf_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_data   (in_data),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data),
    .state_q   (state_q)
);

// File: tb/test_ts_pidf_top.sv
module test_ts_pidf_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [16:0] reg_wdata = '0;
    logic [16:0] reg_rdata;
    logic        out_valid, out_sop, out_order;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    ts_pidf_top i_ts_pidf_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .out_order(out_order)
    );

    int checks = 0, errors = 0;
    int cyc = 0;
    logic [16:0] model [8];

    logic [7:0] rx_d [1024];
    logic       rx_s [1024];
    logic       rx_o [1024];
    int         rx_n = 0;
    int         rx_sop_cyc = -1;
    logic [7:0] ex_d [1024];
    logic       ex_s [1024];
    int         ex_n = 0;
    int         sync_cyc = -1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && rx_n < 1024) begin
            rx_d[rx_n] = out_data;
            rx_s[rx_n] = out_sop;
            rx_o[rx_n] = out_order;
            if (out_sop && rx_sop_cyc < 0) rx_sop_cyc = cyc;
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mask_of(input int s);
        return (s == 0) ? 17'h1FFFF : 17'h09FFF;
    endfunction

    function automatic bit pass_of(input logic [12:0] pid);
        bit hit = 0;
        for (int k = 0; k < 8; k++)
            if (model[k][15] && model[k][12:0] == pid) hit = 1;
        return model[0][16] || (!model[0][13] && hit);
    endfunction

    function automatic logic [7:0] byte_of(input logic [12:0] pid, input logic [7:0] seed,
                                           input bit bad, input int i);
        if (i == 0) return bad ? 8'h46 : 8'h47;
        if (i == 1) return {3'b101, pid[12:8]};
        if (i == 2) return pid[7:0];
        return seed + 8'(i * 7);
    endfunction

    task automatic wr(input logic [4:0] a, input logic [16:0] v);
        @(posedge clk); #2;
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #2;
        reg_we = 1'b0;
        if (a[1:0] == 2'b00) model[a[4:2]] = v & mask_of(int'(a[4:2]));
    endtask

    task automatic rd(input logic [4:0] a, output logic [16:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0; in_sop = 1'b0;
        end
    endtask

    task automatic expect_pkt(input logic [12:0] pid, input logic [7:0] seed, input bit bad);
        if (!bad && pass_of(pid)) begin
            for (int i = 0; i < 188; i++) begin
                ex_d[ex_n] = byte_of(pid, seed, 1'b0, i);
                ex_s[ex_n] = (i == 0);
                ex_n++;
            end
        end
    endtask

    task automatic send(input logic [12:0] pid, input logic [7:0] seed, input bit bad,
                        input int gap_at, input int sop_at);
        for (int i = 0; i < 188; i++) begin
            if (i == gap_at) begin
                @(posedge clk); #2;
                in_valid = 1'b0; in_sop = 1'b0;
            end
            @(posedge clk); #2;
            in_valid = 1'b1;
            in_sop   = (i == 0) || (i == sop_at);
            in_data  = byte_of(pid, seed, bad, i);
            if (i == 0 && sync_cyc < 0) sync_cyc = cyc;
        end
    endtask

    task automatic compare(input string req, input logic exp_ord);
        int mism = 0;
        idle(6);
        chk(rx_n == ex_n, req, rx_n, ex_n);
        for (int i = 0; i < ex_n && i < rx_n; i++)
            if (rx_d[i] !== ex_d[i] || rx_s[i] !== ex_s[i] || rx_o[i] !== exp_ord) mism++;
        chk(mism == 0, {req, " content"}, mism, 0);
        rx_n = 0; ex_n = 0; rx_sop_cyc = -1; sync_cyc = -1;
    endtask

    task automatic pkt(input logic [12:0] pid, input logic [7:0] seed, input string req);
        expect_pkt(pid, seed, 1'b0);
        send(pid, seed, 1'b0, -1, -1);
        compare(req, model[0][14]);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [16:0] v;
        logic [12:0] p;
        model[0] = 17'h03FFF;
        for (int k = 1; k < 8; k++) model[k] = 17'h01FFF;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        for (int k = 0; k < 8; k++) begin
            rd(5'(k << 2), v);
            chk(v == ((k == 0) ? 17'h03FFF : 17'h01FFF), "R1 slot reset", v, (k == 0) ? 17'h03FFF : 17'h01FFF);
        end

        // R2 masking, placement, misaligned access
        wr(5'h0C, 17'h1FFFF); rd(5'h0C, v); chk(v == 17'h09FFF, "R2 slot mask", v, 17'h09FFF);
        wr(5'h00, 17'h1FFFF); rd(5'h00, v); chk(v == 17'h1FFFF, "R2 ctl mask", v, 17'h1FFFF);
        wr(5'h0D, 17'h00000); rd(5'h0C, v); chk(v == 17'h09FFF, "R2 misaligned write", v, 17'h09FFF);
        rd(5'h0D, v); chk(v == 17'h0, "R2 misaligned read", v, 0);
        rd(5'h08, v); chk(v == 17'h01FFF, "R2 neighbour untouched", v, 17'h01FFF);

        // configure slots: slot k enabled with a distinct identifier, slot 7 disabled
        wr(5'h00, 17'h08000 | 17'h0011);
        for (int k = 1; k < 7; k++) wr(5'(k << 2), 17'h08000 | 17'(13'h100 * k + 13'h11 + k));
        wr(5'h1C, 17'h00ABC);

        // R5 / R4 sweep: exact, neighbour, bit-12 alias
        for (int k = 0; k < 8; k++) begin
            p = model[k][12:0];
            pkt(p, 8'(k), "R5 exact");
            pkt(p ^ 13'h0001, 8'(k + 20), "R5 neighbour");
            pkt(p ^ 13'h1000, 8'(k + 40), "R4 bit12");
        end
        pkt(13'h1FFF, 8'h33, "R5 null pid");

        // R6 block all
        wr(5'h00, model[0] | 17'h02000);
        pkt(13'h0011, 8'h51, "R6 blocked hit");
        // R7 pass all, with blocking still set
        wr(5'h00, model[0] | 17'h10000);
        pkt(13'h0999, 8'h52, "R7 pass miss");
        // R12 order bit
        wr(5'h00, model[0] | 17'h04000);
        pkt(13'h0777, 8'h53, "R12 order");
        wr(5'h00, 17'h08011);

        // R3 bad sync, stray bytes, then a good packet
        expect_pkt(13'h0011, 8'h60, 1'b1);
        send(13'h0011, 8'h60, 1'b1, -1, -1);
        compare("R3 bad sync", 1'b0);
        @(posedge clk); #2 in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h47;
        @(posedge clk); #2 in_sop = 1'b0; in_data = 8'h12;
        pkt(13'h0011, 8'h61, "R3 after stray");

        // R9 header gaps drop, body gap keeps
        send(13'h0011, 8'h70, 1'b0, 1, -1); compare("R9 gap byte1", 1'b0);
        send(13'h0011, 8'h71, 1'b0, 2, -1); compare("R9 gap byte2", 1'b0);
        expect_pkt(13'h0011, 8'h72, 1'b0);
        send(13'h0011, 8'h72, 1'b0, 50, -1); compare("R9 body gap", 1'b0);

        // R10 start strobe inside body, back-to-back packets
        expect_pkt(13'h0011, 8'h80, 1'b0);
        send(13'h0011, 8'h80, 1'b0, -1, 100); compare("R10 inner sop", 1'b0);
        expect_pkt(13'h0011, 8'h81, 1'b0); send(13'h0011, 8'h81, 1'b0, -1, -1);
        expect_pkt(13'h0555, 8'h82, 1'b0); send(13'h0555, 8'h82, 1'b0, -1, -1);
        expect_pkt(13'h0112, 8'h83, 1'b0); send(13'h0112, 8'h83, 1'b0, -1, -1);
        compare("R10 back-to-back", 1'b0);

        // R8 latency
        expect_pkt(13'h0011, 8'h90, 1'b0);
        send(13'h0011, 8'h90, 1'b0, -1, -1);
        idle(6);
        chk(rx_sop_cyc - sync_cyc == 3, "R8 latency", rx_sop_cyc - sync_cyc, 3);
        compare("R8 packet", 1'b0);

        // R11 write during a packet applies to the next one
        expect_pkt(13'h0AAA, 8'hA0, 1'b0);
        fork
            send(13'h0AAA, 8'hA0, 1'b0, -1, -1);
            begin repeat (40) @(posedge clk); wr(5'h1C, 17'h08AAA); end
        join
        compare("R11 mid-packet write", 1'b0);
        pkt(13'h0AAA, 8'hA1, "R11 next packet");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule